// File: doc/BRIEF.md
# Asynchronous Serial Channel Datapath

This block is the character-level datapath of one asynchronous serial channel. On the transmit side a single-byte holding buffer feeds a frame shift register that puts a start bit, the data bits (least significant first) and one or two stop bits onto the line. One bit leaves per pulse of a bit-clock enable. The line is held at mark while the transmitter is disabled and forced low while a break is requested. On the receive side a bit-serial receiver, paced by the same enable, collects characters into a two-entry FIFO. The FIFO raises a sticky overrun flag when a character arrives while it is already full.

A host writes bytes through a data-port write strobe and reads received bytes through a data-port read strobe. It watches transmit-buffer-empty, all-sent, receive-available and overrun. Word length (5 to 8 bits) is set separately for each direction, and the stop-bit count applies to the transmitter. Baud-rate generation lies outside the block: the bit-clock enable is one clock-wide pulse per bit time.

Top module: `serial_chan_dp`

## Requirements
- R1: While tx_en is 0, txd is 1, whatever brk and the shifter state are.
- R2: While tx_en is 1 and brk is 1, txd is 0.
- R3: A loaded character appears on txd as a 0 start bit, then N data bits least significant first, then one stop bit (tx_stop2=0) or two stop bits (tx_stop2=1) at 1. N is 5 + tx_len, where tx_len code 0..3 selects 5..8 bits. The start bit appears on the clock after the load, and each later bit starts on the clock after a bit_en pulse.
- R4: A write while the shifter is idle, tx_en is 1 and the buffer is empty loads the shifter at once, and tx_empty stays 1. Any other write places the byte in the buffer (the newest byte replaces an older buffered one) and clears tx_empty.
- R5: A buffered byte moves to the shifter, setting tx_empty, when tx_en is 1 and brk is 0 and either a character completes or the shifter is idle. While brk is 1 the buffered byte is held.
- R6: all_sent clears on every data write. It sets when a character completes with the buffer empty.
- R7: The receiver, sampling rxd on bit_en pulses, starts on a 0 sample. It then takes 5 + rx_len data bits least significant first, zero-fills the upper bits, and pushes the character on the following stop-bit sample.
- R8: While rx_en is 0 the receiver takes no bits, returns to idle and pushes nothing.
- R9: rd_data shows the oldest held character, or 0 when none is held. A rd_stb pulse pops it, and rx_avail is 1 exactly when at least one character is held.
- R10: A character arriving while two are held (and no pop occurs in the same cycle) replaces the newer entry and sets rx_ovr. rx_ovr stays set until reset.
- R11: After reset, txd is 1, tx_empty and all_sent are 1, and rx_avail, rx_ovr and rd_data are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse per bit time |
| wr_stb | input | 1 | Data-port write strobe |
| wr_data | input | 8 | Byte to transmit |
| rd_stb | input | 1 | Data-port read strobe (pops FIFO) |
| tx_en | input | 1 | Transmitter enable |
| brk | input | 1 | Send-break request |
| tx_len | input | 2 | Transmit word length code (5 + code bits) |
| tx_stop2 | input | 1 | 1 selects two stop bits |
| rx_en | input | 1 | Receiver enable |
| rx_len | input | 2 | Receive word length code (5 + code bits) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rd_data | output | 8 | Oldest received character, 0 when empty |
| tx_empty | output | 1 | Transmit buffer empty |
| all_sent | output | 1 | Shifter finished with nothing buffered |
| rx_avail | output | 1 | FIFO holds at least one character |
| rx_ovr | output | 1 | Sticky receive overrun |

## Verification
A wrong bit counter or shift order in the transmitter shows on txd within one character, as a misplaced or missing stop bit or a reordered data bit. The bench compares whole frames against frames it builds itself for every length and stop-bit setting. A buffer flag that goes stale shows at the next character boundary: tx_empty or all_sent disagrees with the write history, or a held byte goes out under break. Receiver or FIFO faults show on the first rd_data after a push: a wrong character, the wrong entry kept after overrun, or rx_avail set after the last pop.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int DATA_W   = 8;
  localparam int LEN_W    = 2;
  localparam int LEN_MIN  = 5;
  localparam int STOP_MAX = 2;
  localparam int FRAME_W  = 1 + DATA_W + STOP_MAX;
  localparam int FCNT_W   = $clog2(FRAME_W + 1);
  localparam int BIDX_W   = $clog2(DATA_W);

  typedef enum logic [1:0] {RX_IDLE, RX_DATA, RX_STOP} rx_state_e;

  // number of data bits selected by a length code
  function automatic int word_bits(input logic [LEN_W-1:0] code);
    return LEN_MIN + int'(code);
  endfunction

  // total line bits of one character: start + data + stops
  function automatic int frame_bits(input logic [LEN_W-1:0] code, input logic two_stop);
    return 1 + word_bits(code) + (two_stop ? 2 : 1);
  endfunction

  // clear bits above the selected word length
  function automatic logic [DATA_W-1:0] trim_word(input logic [DATA_W-1:0] d,
                                                  input logic [LEN_W-1:0] code);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = (i < word_bits(code)) ? d[i] : 1'b0;
    return r;
  endfunction

  // line image, bit 0 first out: start 0, data, then ones (stop bits)
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [DATA_W-1:0] d,
                                                    input logic [LEN_W-1:0] code);
    logic [FRAME_W-1:0] f;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < word_bits(code)) f[i+1] = d[i];
    return f;
  endfunction
endpackage

// File: rtl/scd_tx.sv
module scd_tx
  import scd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_en,
  input  logic              brk,
  input  logic [LEN_W-1:0]  len,
  input  logic              stop2,
  output logic              txd,
  output logic              tx_empty,
  output logic              all_sent,
  output logic              tx_idle,
  output logic              tx_done
);
  logic [DATA_W-1:0]  buf_q;
  logic               buf_full_q;
  logic [FRAME_W-1:0] sr_q;
  logic [FCNT_W-1:0]  cnt_q;
  logic               busy_q;
  logic               sent_q;

  logic wr_direct, load_buf, slot_free;

  assign tx_done   = busy_q && bit_en && (cnt_q == FCNT_W'(1));
  assign slot_free = !busy_q || tx_done;
  assign wr_direct = wr_stb && !busy_q && tx_en && !buf_full_q;
  assign load_buf  = buf_full_q && tx_en && !brk && slot_free && !wr_direct;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q      <= '0;
      buf_full_q <= 1'b0;
      sr_q       <= '1;
      cnt_q      <= '0;
      busy_q     <= 1'b0;
      sent_q     <= 1'b1;
    end else begin
      if (wr_direct) begin
        sr_q   <= pack_frame(wr_data, len);
        cnt_q  <= FCNT_W'(frame_bits(len, stop2));
        busy_q <= 1'b1;
      end else if (load_buf) begin
        sr_q       <= pack_frame(buf_q, len);
        cnt_q      <= FCNT_W'(frame_bits(len, stop2));
        busy_q     <= 1'b1;
        buf_full_q <= 1'b0;
      end else if (busy_q && bit_en) begin
        sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
        cnt_q <= cnt_q - FCNT_W'(1);
        if (tx_done) busy_q <= 1'b0;
      end
      if (wr_stb && !wr_direct) begin
        buf_q      <= wr_data;
        buf_full_q <= 1'b1;
      end
      if (wr_stb) sent_q <= 1'b0;
      else if (tx_done && !buf_full_q) sent_q <= 1'b1;
    end
  end

  // line priority: disabled mark, then break, then shifter
  always_comb begin
    if (!tx_en)      txd = 1'b1;
    else if (brk)    txd = 1'b0;
    else if (busy_q) txd = sr_q[0];
    else             txd = 1'b1;
  end

  assign tx_empty = !buf_full_q;
  assign all_sent = sent_q;
  assign tx_idle  = !busy_q;
endmodule

// File: rtl/scd_rx.sv
module scd_rx
  import scd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_en,
  input  logic [LEN_W-1:0]  len,
  input  logic              rxd,
  output logic              push,
  output logic [DATA_W-1:0] push_data
);
  rx_state_e         st_q;
  logic [BIDX_W-1:0] idx_q;
  logic [DATA_W-1:0] sr_q;
  logic              last_bit;

  assign last_bit  = (int'(idx_q) == word_bits(len) - 1);
  assign push      = rx_en && bit_en && (st_q == RX_STOP);
  assign push_data = trim_word(sr_q, len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      idx_q <= '0;
      sr_q  <= '0;
    end else if (!rx_en) begin
      st_q  <= RX_IDLE;
      idx_q <= '0;
    end else if (bit_en) begin
      unique case (st_q)
        RX_IDLE: if (!rxd) begin
          st_q  <= RX_DATA;
          idx_q <= '0;
          sr_q  <= '0;
        end
        RX_DATA: begin
          sr_q[idx_q] <= rxd;
          if (last_bit) st_q <= RX_STOP;
          else          idx_q <= idx_q + BIDX_W'(1);
        end
        RX_STOP: st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scd_rx_fifo.sv
module scd_rx_fifo
  import scd_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head,
  output logic              avail,
  output logic              ovr
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] nxt   [DEPTH];
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     cnt_nxt;
  logic              pop, full_push;

  assign pop = pop_req && (cnt_q != '0);

  always_comb begin
    int n;
    for (int i = 0; i < DEPTH; i++) nxt[i] = mem_q[i];
    n = int'(cnt_q);
    if (pop) begin
      for (int i = 0; i < DEPTH; i++) nxt[i] = (i < DEPTH - 1) ? mem_q[i+1] : '0;
      n = n - 1;
    end
    full_push = push && (n == DEPTH);
    if (push) begin
      if (n == DEPTH) nxt[DEPTH-1] = push_data;
      else begin
        for (int i = 0; i < DEPTH; i++) if (i == n) nxt[i] = push_data;
        n = n + 1;
      end
    end
    cnt_nxt = CW'(n);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else        mem_q[g] <= nxt[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovr   <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (full_push) ovr <= 1'b1;
    end
  end

  assign avail = (cnt_q != '0);
  assign head  = avail ? mem_q[0] : '0;
endmodule

// File: rtl/serial_chan_dp.sv
module serial_chan_dp
  import scd_pkg::*;
#(
  parameter int RX_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  input  logic              tx_en,
  input  logic              brk,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              tx_stop2,
  input  logic              rx_en,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              rxd,
  output logic              txd,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx_empty,
  output logic              all_sent,
  output logic              rx_avail,
  output logic              rx_ovr
);
  logic              tx_done_w, tx_idle_w, rx_push_w;
  logic [DATA_W-1:0] rx_word_w;

  scd_tx u_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .tx_en(tx_en), .brk(brk), .len(tx_len), .stop2(tx_stop2), .txd(txd),
    .tx_empty(tx_empty), .all_sent(all_sent), .tx_idle(tx_idle_w), .tx_done(tx_done_w)
  );

  scd_rx u_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_en(rx_en), .len(rx_len),
    .rxd(rxd), .push(rx_push_w), .push_data(rx_word_w)
  );

  scd_rx_fifo #(.DEPTH(RX_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_push_w), .push_data(rx_word_w),
    .pop_req(rd_stb), .head(rd_data), .avail(rx_avail), .ovr(rx_ovr)
  );
endmodule

// File: rtl/scd_checker.sv
module scd_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic rd_stb,
  input logic tx_en,
  input logic brk,
  input logic rx_en,
  input logic txd,
  input logic tx_empty,
  input logic all_sent,
  input logic rx_avail,
  input logic rx_ovr,
  input logic tx_done,
  input logic tx_idle,
  input logic rx_push
);
  assert_mark_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> txd);

  assert_break_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && brk) |-> !txd);

  assert_direct_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && tx_en && tx_idle && tx_empty) |=> tx_empty);

  assert_idle_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !brk && tx_idle && !tx_empty && !wr_stb) |=> tx_empty);

  assert_write_clears_sent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !all_sent);

  assert_sent_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_sent) |-> $past(tx_done));

  assert_no_push_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rx_push);

  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rx_avail && !rx_push) |=> !rx_avail);

  assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |=> rx_ovr);
endmodule

bind serial_chan_dp scd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .tx_en(tx_en),
  .brk(brk), .rx_en(rx_en), .txd(txd), .tx_empty(tx_empty), .all_sent(all_sent),
  .rx_avail(rx_avail), .rx_ovr(rx_ovr), .tx_done(tx_done_w), .tx_idle(tx_idle_w),
  .rx_push(rx_push_w)
);

// File: tb/serial_chan_dp_tb.sv
`timescale 1ns/1ps
module serial_chan_dp_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_en = 1'b1, brk = 1'b0, tx_stop2 = 1'b0, rx_en = 1'b1, rxd = 1'b1;
  logic [1:0] tx_len = 2'd3, rx_len = 2'd3;
  logic       txd, tx_empty, all_sent, rx_avail, rx_ovr;
  logic [7:0] rd_data;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  serial_chan_dp u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .tx_en(tx_en), .brk(brk), .tx_len(tx_len), .tx_stop2(tx_stop2),
    .rx_en(rx_en), .rx_len(rx_len), .rxd(rxd), .txd(txd), .rd_data(rd_data),
    .tx_empty(tx_empty), .all_sent(all_sent), .rx_avail(rx_avail), .rx_ovr(rx_ovr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk) begin wr_stb = 1'b1; wr_data = b; end
    @(negedge clk) wr_stb = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // expected number of line bits for a length code and stop setting
  function automatic int nbits(input int l, input int s2);
    return 1 + (5 + l) + (s2 != 0 ? 2 : 1);
  endfunction

  // start bit must be on the line now; samples all bits up to the last stop bit
  task automatic frame_body(input logic [7:0] d, input int l, input int s2, input string tag);
    logic [15:0] got, exp;
    int n;
    n = nbits(l, s2);
    got = '0; exp = '0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) tick();
      got[i] = txd;
      exp[i] = (i == 0) ? 1'b0 : (i <= 5 + l) ? d[i-1] : 1'b1;
    end
    chk(tag, {16'h0, got}, {16'h0, exp});
  endtask

  task automatic send_rx(input logic [7:0] d, input int l);
    rxd = 1'b0; tick();
    for (int i = 0; i < 5 + l; i++) begin rxd = d[i]; tick(); end
    rxd = 1'b1; tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] pat [4];
    pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'h96; pat[3] = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 txd", txd, 1); chk("R11 tx_empty", tx_empty, 1);
    chk("R11 all_sent", all_sent, 1); chk("R11 rx_avail", rx_avail, 0);
    chk("R11 rx_ovr", rx_ovr, 0); chk("R11 rd_data", rd_data, 0);

    // R3 sweep of length, stop bits and pattern; R4/R6 flags per frame
    for (int l = 0; l < 4; l++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 4; p++) begin
          tx_len = 2'(l); tx_stop2 = 1'(s);
          wr(pat[p] ^ 8'(l * 16 + s));
          chk("R4 direct load keeps tx_empty", tx_empty, 1);
          chk("R6 write clears all_sent", all_sent, 0);
          frame_body(pat[p] ^ 8'(l * 16 + s), l, s, "R3 frame");
          tick();
          chk("R6 all_sent at end", all_sent, 1);
          chk("R3 idle mark", txd, 1);
        end

    // R4/R5 back-to-back writes
    tx_len = 2'd2; tx_stop2 = 1'b0;
    wr(8'h5B); wr(8'h24);
    chk("R4 buffered clears tx_empty", tx_empty, 0);
    frame_body(8'h5B, 2, 0, "R3 first of pair");
    tick();
    chk("R5 reload at completion", tx_empty, 1);
    chk("R6 not sent while second runs", all_sent, 0);
    frame_body(8'h24, 2, 0, "R5 second of pair");
    tick();
    chk("R6 all_sent after pair", all_sent, 1);

    // R1/R4/R5 write while disabled, then enable
    tx_en = 1'b0;
    wr(8'h6E);
    chk("R4 disabled write buffers", tx_empty, 0);
    chk("R1 mark while disabled", txd, 1);
    repeat (3) tick();
    chk("R1 still mark", txd, 1);
    chk("R5 held while disabled", tx_empty, 0);
    tx_en = 1'b1;
    @(negedge clk);
    chk("R5 idle drain on enable", tx_empty, 1);
    frame_body(8'h6E, 2, 0, "R5 drained frame");
    tick();

    // R1 disable mid-frame; R2 break priority
    tx_len = 2'd3;
    wr(8'h0F); tick(); tick();
    tx_en = 1'b0; brk = 1'b1;
    @(negedge clk);
    chk("R1 mark over break mid-frame", txd, 1);
    tx_en = 1'b1;
    @(negedge clk);
    chk("R2 break forces low", txd, 0);
    brk = 1'b0;
    repeat (8) tick();
    chk("R6 all_sent after interrupted frame", all_sent, 1);

    // R5 break holds buffered byte
    brk = 1'b1;
    @(negedge clk);
    chk("R2 break on idle line", txd, 0);
    wr(8'h33);
    chk("R4 direct load under break", tx_empty, 1);
    wr(8'h44);
    chk("R4 second write buffered", tx_empty, 0);
    repeat (10) tick();
    chk("R5 held under break", tx_empty, 0);
    chk("R6 not sent under break", all_sent, 0);
    brk = 1'b0;
    @(negedge clk);
    chk("R5 drain after break", tx_empty, 1);
    frame_body(8'h44, 3, 0, "R5 frame after break");
    tick();
    chk("R6 all_sent final", all_sent, 1);

    // R7/R9 receive sweep
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 4; p++) begin
        logic [7:0] m;
        rx_len = 2'(l);
        m = pat[p] & 8'((1 << (5 + l)) - 1);
        send_rx(pat[p], l);
        chk("R7 rx_avail after char", rx_avail, 1);
        chk("R7 received word", rd_data, m);
        rd();
        chk("R9 empty after pop", rx_avail, 0);
        chk("R9 rd_data zero when empty", rd_data, 0);
      end

    // R8 receiver disabled
    rx_en = 1'b0;
    send_rx(8'h5A, 3);
    chk("R8 nothing taken while off", rx_avail, 0);
    rx_en = 1'b1;
    rd();
    chk("R9 pop on empty", rx_avail, 0);

    // R10 overrun
    rx_len = 2'd3;
    send_rx(8'h11, 3); send_rx(8'h22, 3);
    chk("R10 no ovr at two", rx_ovr, 0);
    chk("R9 oldest first", rd_data, 8'h11);
    send_rx(8'h33, 3);
    chk("R10 ovr set", rx_ovr, 1);
    rd();
    chk("R9 pop keeps second slot", rd_data, 8'h33);
    chk("R10 newest replaced last entry", rx_avail, 1);
    rd();
    chk("R9 empty after two pops", rx_avail, 0);
    chk("R10 ovr sticky", rx_ovr, 1);
    do_reset();
    chk("R11 ovr cleared by reset", rx_ovr, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule